// File: doc/BRIEF.md
# Real-Time Clock Timekeeping Core with Frozen-Access Handshake

This block keeps time of day in binary seconds, minutes and hours. A prescaler driven by the RTC clock divides it down to a one-second tick. Each tick advances the time counters. A small register bus in the RTC clock domain lets software freeze the time counters, read or rewrite them coherently, and then let them run again. The prescaler keeps counting during the freeze. A tick that falls inside the freeze is remembered and applied once the counters run again, so an access window shorter than one second loses no time. Rewriting the seconds value restarts the prescaler and discards that remembered tick.

A fixed-period event can be chosen as every second, every minute or every hour. It sets a sticky flag that software clears by writing zero to it. That event and an externally supplied alarm flag share one interrupt pulse output. Software tells the two sources apart by reading both flags in the control register.

Register map (2-bit address, 8-bit data). Address 0 is control: bit 0 freeze request (read/write), bit 1 freeze status (read only), bit 2 periodic flag, bit 3 alarm input (read only), bits 5:4 periodic select, bits 7:6 read 0. Address 1 is seconds, address 2 is minutes and address 3 is hours. Each reads back zero-extended.

Top module: `rtc_time_core`

## Requirements
- R1: While the freeze request (control bit 0) is 1, the seconds, minutes and hours values do not advance. After the request returns to 0, counting resumes.
- R2: Control bit 1 reads 1 starting one clock edge after the edge that set the request, and reads 0 one edge after the edge that cleared it. Counting stays stopped while either bit is 1.
- R3: The prescaler wraps every PRESC_MAX+1 clocks and keeps running during a freeze. Each wrap advances the seconds value by one when the counters are running.
- R4: A wrap during a freeze is held pending. It advances the seconds value exactly once, on the first clock after the freeze ends.
- R5: An accepted write to seconds loads the value, restarts the prescaler from 0 and discards a pending wrap. The next advance then follows PRESC_MAX+1 clocks after that write.
- R6: Writes to seconds, minutes or hours are ignored unless control bit 1 reads 1. A value above 59 (seconds, minutes) or above 23 (hours) is also ignored.
- R7: Seconds and minutes wrap from 59 to 0 and carry into the next value. Hours wrap from 23 to 0.
- R8: Control bits 5:4 select the periodic event: 00 none, 01 every seconds advance, 10 when seconds wrap, 11 when minutes wrap. The event sets the flag in control bit 2.
- R9: A control write with bit 2 equal to 0 clears the flag. A write with bit 2 equal to 1 leaves it unchanged. A new event in the same cycle wins over the clear.
- R10: The interrupt output is a one-clock pulse one edge after a periodic event or after a rising edge of the alarm input. Control bit 3 reads the alarm input.
- R11: After reset every register reads 0 and the interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | RTC clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| alarm_flag_i | input | 1 | Alarm match flag from outside the block |
| irq_o | output | 1 | Shared interrupt pulse |

## Verification
A lost or duplicated pending tick appears as a seconds value one off from the expected value. This can be read out within three clocks of the freeze ending. A prescaler that is not restarted by a seconds write shows up as the next advance arriving at the wrong clock. The bench catches it within one prescaler period, because every timing check is counted from that write. A wrong carry, select decode or flag clear shows on the time registers, the flag bit or the interrupt pin at the first tick that should have caused or withheld it.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int SEC_W    = 6;
    localparam int HR_W     = 5;
    localparam int SEC_LAST = 59;
    localparam int HR_LAST  = 23;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_SEC  = 2'd1;
    localparam logic [ADDR_W-1:0] A_MIN  = 2'd2;
    localparam logic [ADDR_W-1:0] A_HOUR = 2'd3;

    typedef enum logic [1:0] {
        FP_OFF  = 2'b00,
        FP_SEC  = 2'b01,
        FP_MIN  = 2'b10,
        FP_HOUR = 2'b11
    } fp_sel_e;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [SEC_W-1:0] min;
        logic [HR_W-1:0]  hour;
        logic             pend;
    } time_st_t;

    typedef struct packed {
        logic    req;
        logic    stat;
        fp_sel_e sel;
        logic    flag;
        logic    alarm_q;
        logic    irq;
    } ctrl_st_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRESC_W   = 16,
    parameter int PRESC_MAX = 32767
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam logic [PRESC_W-1:0] TOP = PRESC_W'(PRESC_MAX);

    typedef struct packed {
        logic [PRESC_W-1:0] cnt;
    } psc_st_t;

    psc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = (st_q.cnt == TOP);
        if (clr) begin
            st_d.cnt = '0;
            tick     = 1'b0;
        end else if (tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rtc_time_regs.sv
module rtc_time_regs
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              frozen,
    input  logic              sec_wr,
    input  logic              min_wr,
    input  logic              hr_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [SEC_W-1:0]  sec,
    output logic [SEC_W-1:0]  min,
    output logic [HR_W-1:0]   hour,
    output logic              adv,
    output logic              sec_carry,
    output logic              min_carry,
    output logic              sec_wr_ok,
    output logic              pend
);
    localparam logic [SEC_W-1:0]  S_LAST = SEC_W'(SEC_LAST);
    localparam logic [HR_W-1:0]   H_LAST = HR_W'(HR_LAST);
    localparam logic [DATA_W-1:0] W_SLIM = DATA_W'(SEC_LAST);
    localparam logic [DATA_W-1:0] W_HLIM = DATA_W'(HR_LAST);

    time_st_t st_d, st_q;
    logic     min_ok, hr_ok;

    always_comb begin
        st_d      = st_q;
        adv       = !frozen && (tick || st_q.pend);
        sec_carry = adv && (st_q.sec == S_LAST);
        min_carry = sec_carry && (st_q.min == S_LAST);
        sec_wr_ok = sec_wr && (wdata <= W_SLIM);
        min_ok    = min_wr && (wdata <= W_SLIM);
        hr_ok     = hr_wr && (wdata <= W_HLIM);

        if (frozen) st_d.pend = st_q.pend | tick;
        else        st_d.pend = st_q.pend & tick;

        if (adv) begin
            st_d.sec = sec_carry ? '0 : st_q.sec + 1'b1;
            if (sec_carry) st_d.min = min_carry ? '0 : st_q.min + 1'b1;
            if (min_carry) st_d.hour = (st_q.hour == H_LAST) ? '0 : st_q.hour + 1'b1;
        end

        if (sec_wr_ok) begin
            st_d.sec  = wdata[SEC_W-1:0];
            st_d.pend = 1'b0;
        end
        if (min_ok) st_d.min  = wdata[SEC_W-1:0];
        if (hr_ok)  st_d.hour = wdata[HR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sec  = st_q.sec;
    assign min  = st_q.min;
    assign hour = st_q.hour;
    assign pend = st_q.pend;
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              req_bit,
    input  logic              flag_bit,
    input  logic [1:0]        sel_bits,
    input  logic              alarm_i,
    input  logic              adv,
    input  logic              sec_carry,
    input  logic              min_carry,
    output logic              wait_req,
    output logic              wait_stat,
    output logic              frozen,
    output fp_sel_e           fp_sel,
    output logic              fp_flag,
    output logic              fp_evt,
    output logic              irq,
    output logic              sec_wr,
    output logic              min_wr,
    output logic              hr_wr
);
    ctrl_st_t st_d, st_q;
    logic     ctrl_wr;

    always_comb begin
        st_d    = st_q;
        ctrl_wr = bus_wr && (bus_addr == A_CTRL);
        frozen  = st_q.req | st_q.stat;
        sec_wr  = bus_wr && (bus_addr == A_SEC)  && st_q.stat;
        min_wr  = bus_wr && (bus_addr == A_MIN)  && st_q.stat;
        hr_wr   = bus_wr && (bus_addr == A_HOUR) && st_q.stat;

        unique case (st_q.sel)
            FP_SEC:  fp_evt = adv;
            FP_MIN:  fp_evt = sec_carry;
            FP_HOUR: fp_evt = min_carry;
            default: fp_evt = 1'b0;
        endcase

        st_d.stat = st_q.req;
        if (ctrl_wr) begin
            st_d.req = req_bit;
            st_d.sel = fp_sel_e'(sel_bits);
        end

        if (fp_evt)                 st_d.flag = 1'b1;
        else if (ctrl_wr && !flag_bit) st_d.flag = 1'b0;

        st_d.alarm_q = alarm_i;
        st_d.irq     = fp_evt | (alarm_i & ~st_q.alarm_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wait_req  = st_q.req;
    assign wait_stat = st_q.stat;
    assign fp_sel    = st_q.sel;
    assign fp_flag   = st_q.flag;
    assign irq       = st_q.irq;
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
#(
    parameter int PRESC_W   = 16,
    parameter int PRESC_MAX = 32767
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              alarm_flag_i,
    output logic              irq_o
);
    logic             tick, adv, sec_carry, min_carry, sec_wr_ok, pend;
    logic             wait_req, wait_stat, frozen, fp_flag, fp_evt;
    logic             sec_wr, min_wr, hr_wr;
    fp_sel_e          fp_sel;
    logic [SEC_W-1:0] sec, min;
    logic [HR_W-1:0]  hour;

    rtc_prescaler #(.PRESC_W(PRESC_W), .PRESC_MAX(PRESC_MAX)) u_psc (
        .clk (clk),
        .rst_n (rst_n),
        .clr (sec_wr_ok),
        .tick (tick)
    );

    rtc_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .req_bit   (bus_wdata[0]),
        .flag_bit  (bus_wdata[2]),
        .sel_bits  (bus_wdata[5:4]),
        .alarm_i   (alarm_flag_i),
        .adv       (adv),
        .sec_carry (sec_carry),
        .min_carry (min_carry),
        .wait_req  (wait_req),
        .wait_stat (wait_stat),
        .frozen    (frozen),
        .fp_sel    (fp_sel),
        .fp_flag   (fp_flag),
        .fp_evt    (fp_evt),
        .irq       (irq_o),
        .sec_wr    (sec_wr),
        .min_wr    (min_wr),
        .hr_wr     (hr_wr)
    );

    rtc_time_regs u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .frozen    (frozen),
        .sec_wr    (sec_wr),
        .min_wr    (min_wr),
        .hr_wr     (hr_wr),
        .wdata     (bus_wdata),
        .sec       (sec),
        .min       (min),
        .hour      (hour),
        .adv       (adv),
        .sec_carry (sec_carry),
        .min_carry (min_carry),
        .sec_wr_ok (sec_wr_ok),
        .pend      (pend)
    );

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = {2'b00, fp_sel, alarm_flag_i, fp_flag, wait_stat, wait_req};
            A_SEC:   bus_rdata = {{(DATA_W-SEC_W){1'b0}}, sec};
            A_MIN:   bus_rdata = {{(DATA_W-SEC_W){1'b0}}, min};
            default: bus_rdata = {{(DATA_W-HR_W){1'b0}}, hour};
        endcase
    end
endmodule

// File: rtl/rtc_time_core_chk.sv
module rtc_time_core_chk
    import rtc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wait_req,
    input logic             wait_stat,
    input logic [SEC_W-1:0] sec,
    input logic             fp_evt,
    input logic             fp_flag,
    input logic             sec_wr_ok,
    input logic             pend,
    input logic             irq_o
);
    AST_STAT_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wait_req) |=> wait_stat); // R2

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_stat && !sec_wr_ok) |=> $stable(sec)); // R1

    AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sec <= SEC_W'(SEC_LAST)); // R7

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        fp_evt |=> fp_flag); // R8

    AST_PEND_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        sec_wr_ok |=> !pend); // R5

    AST_IRQ_ON_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        fp_evt |=> irq_o); // R10
endmodule

bind rtc_time_core rtc_time_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wait_req  (wait_req),
    .wait_stat (wait_stat),
    .sec       (sec),
    .fp_evt    (fp_evt),
    .fp_flag   (fp_flag),
    .sec_wr_ok (sec_wr_ok),
    .pend      (pend),
    .irq_o     (irq_o)
);

// File: tb/sim_rtc_time_core.sv
`timescale 1ns/1ps
module sim_rtc_time_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       alarm_flag_i = 1'b0;
    logic       irq_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rtc_time_core #(.PRESC_W(16), .PRESC_MAX(15)) u0 (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wr (bus_wr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .alarm_flag_i (alarm_flag_i), .irq_o (irq_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic freeze(input logic [7:0] ctrl);
        wr(2'd0, ctrl | 8'h01);
        wait_n(1);
    endtask

    task automatic t_reset;
        int v;
        rd(2'd0, v); check("R11 ctrl", v, 0);
        rd(2'd1, v); check("R11 sec", v, 0);
        rd(2'd2, v); check("R11 min", v, 0);
        rd(2'd3, v); check("R11 hour", v, 0);
        check("R11 irq", irq_o, 0);
        wr(2'd2, 8'd33);
        rd(2'd2, v); check("R6 min write while running", v, 0);
    endtask

    task automatic t_handshake;
        int v, s0;
        wr(2'd0, 8'h01);
        rd(2'd0, v); check("R2 status not yet", v & 3, 1);
        wait_n(1);
        rd(2'd0, v); check("R2 status set", v & 3, 3);
        rd(2'd1, s0);
        wait_n(40);
        rd(2'd1, v); check("R1 sec frozen", v, s0);
        wr(2'd2, 8'd60);
        rd(2'd2, v); check("R6 min 60 ignored", v, 0);
        wr(2'd3, 8'd24);
        rd(2'd3, v); check("R6 hour 24 ignored", v, 0);
        wr(2'd3, 8'd23);
        rd(2'd3, v); check("R6 hour 23 accepted", v, 23);
        wr(2'd3, 8'd0);
        wr(2'd0, 8'h00);
        rd(2'd0, v); check("R2 status lags clear", v & 3, 2);
        wait_n(1);
        rd(2'd0, v); check("R2 status cleared", v & 3, 0);
    endtask

    task automatic t_pending;
        int v;
        freeze(8'h00);
        wr(2'd1, 8'd10);
        wait_n(20);
        rd(2'd1, v); check("R1 sec frozen with tick", v, 10);
        wr(2'd0, 8'h00);
        wait_n(3);
        rd(2'd1, v); check("R4 pending applied once", v, 11);
        wait_n(10);
        rd(2'd1, v); check("R3 next tick in phase", v, 12);
        wait_n(16);
        rd(2'd1, v); check("R3 tick period", v, 13);
    endtask

    task automatic t_drop;
        int v;
        freeze(8'h00);
        wr(2'd1, 8'd5);
        wait_n(20);
        wr(2'd1, 8'd60);
        rd(2'd1, v); check("R6 sec 60 ignored", v, 5);
        wr(2'd1, 8'd30);
        wr(2'd0, 8'h00);
        wait_n(3);
        rd(2'd1, v); check("R5 pending dropped", v, 30);
        wait_n(13);
        rd(2'd1, v); check("R5 prescaler restarted", v, 31);
    endtask

    task automatic t_carry;
        int v;
        freeze(8'h30);
        wr(2'd2, 8'd59);
        wr(2'd3, 8'd23);
        wr(2'd1, 8'd59);
        wr(2'd0, 8'h30);
        wait_n(15);
        check("R10 irq on hour event", irq_o, 1);
        rd(2'd1, v); check("R7 sec wrap", v, 0);
        rd(2'd2, v); check("R7 min wrap", v, 0);
        rd(2'd3, v); check("R7 hour wrap", v, 0);
        rd(2'd0, v); check("R8 flag on hour event", (v >> 2) & 1, 1);
        wait_n(1);
        check("R10 irq one clock", irq_o, 0);
        wr(2'd0, 8'h04);
        rd(2'd0, v); check("R9 write one keeps flag", (v >> 2) & 1, 1);
        wr(2'd0, 8'h00);
        rd(2'd0, v); check("R9 write zero clears flag", (v >> 2) & 1, 0);
        wait_n(16);
        rd(2'd1, v); check("R3 sec advanced", v, 1);
        rd(2'd0, v); check("R8 select off no flag", (v >> 2) & 1, 0);
    endtask

    task automatic t_minute_sel;
        int v;
        freeze(8'h20);
        wr(2'd2, 8'd10);
        wr(2'd1, 8'd58);
        wr(2'd0, 8'h20);
        wait_n(15);
        rd(2'd1, v); check("R3 sec 59", v, 59);
        check("R8 no minute event yet", irq_o, 0);
        wait_n(16);
        check("R8 minute event irq", irq_o, 1);
        rd(2'd2, v); check("R7 min carry", v, 11);
        rd(2'd1, v); check("R7 sec to zero", v, 0);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_sec_sel;
        int v;
        freeze(8'h10);
        wr(2'd1, 8'd20);
        wr(2'd0, 8'h10);
        wait_n(15);
        check("R8 second event irq", irq_o, 1);
        rd(2'd1, v); check("R8 sec on event", v, 21);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_alarm;
        int v;
        alarm_flag_i = 1'b1;
        wait_n(1);
        check("R10 alarm irq", irq_o, 1);
        rd(2'd0, v); check("R10 alarm bit", (v >> 3) & 1, 1);
        wait_n(1);
        check("R10 alarm pulse ends", irq_o, 0);
        alarm_flag_i = 1'b0;
        wait_n(1);
        rd(2'd0, v); check("R10 alarm bit low", (v >> 3) & 1, 0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        t_reset();
        t_handshake();
        t_pending();
        t_drop();
        t_carry();
        t_minute_sel();
        t_sec_sel();
        t_alarm();
        finish_run();
    end
endmodule